// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a management-bus master for talking to Ethernet PHYs. Software programs a timing/control word that sets the clock divider, the output hold time and whether the preamble is sent. Software then writes a 32-bit frame word, and that write starts the transaction. The block divides the system clock to produce the management clock. It shifts out an optional preamble of 32 ones, followed by the frame word with the most significant bit first. Each new output bit appears a programmable number of system cycles after the falling management-clock edge.

The frame word carries the start code, opcode, PHY address, register or device address, turnaround and data. The block does not interpret the start code, so both clause 22 and clause 45 frames pass through as software composed them. Opcode bit 1 set marks a read frame. For a read frame the master releases the data line for the turnaround and data phases, samples 16 data bits on rising clock edges, and stores them into the low half of the frame word. Every finished transaction raises a sticky event flag, and software clears the flag by writing 1 to it.

A transaction can also start from the timing word itself. This happens when a non-zero frame is waiting and software changes the low control byte of the timing word from zero to non-zero.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: A write to the frame word (select 0) starts a transaction only when timing bits 7:0 are non-zero and no transaction is running. A frame write made while busy changes neither the stored frame nor the transfer in progress.
- R2: A write to the timing word (select 1) starts a transaction when three conditions hold: the stored frame is non-zero, the old timing bits 7:0 are zero, and the new bits 7:0 are non-zero. No other timing write starts one.
- R3: The timing word has its divider D in bits 6:1, and the management clock period is 2*(D+1) system cycles. The clock rests low while idle. With D = 0 the clock never toggles.
- R4: When timing bit 7 is clear, 32 ones precede the frame. When the bit is set, the frame starts at once.
- R5: Frame bits go out MSB first, one bit per clock period. Each bit changes H+1 system cycles after the falling clock edge, where H sits in timing bits 10:8 and software keeps H below D.
- R6: Opcode bit 29 set marks a read frame. On a read frame the output enable is low for frame bits 17:0. The 16 bits sampled on the rising edges of bits 15:0 replace frame bits 15:0, MSB first.
- R7: On a frame with bit 29 clear, the output enable stays high for every bit and the stored frame is left unchanged.
- R8: Status bit 0 is a sticky event flag, set at the end of every transaction. Writing 1 to status bit 0 (select 2) clears it, and writing 0 leaves it set.
- R9: Status bit 1 reads 1 from the cycle after launch until the transaction completes.
- R10: After reset the frame word, timing word and status read 0, the clock is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write select: 0 frame, 1 timing, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read select, same encoding |
| reg_rdata | output | 32 | Read data (combinational) |
| mdio_in | input | 1 | Data line as seen from the pad |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mgmt_evt | output | 1 | Sticky completion event |

## Verification
Suppose the bit index or the divider counter holds a wrong value. The captured bit stream then shows a wrong bit or a wrong bit count within one clock period of the fault. On a read frame, a wrong index also makes the output enable drop early or late. Suppose the hold counter slips. The change of the data line then moves relative to the falling clock edge, and this is visible on the very next bit that differs from the one before it. Wrong launch or busy state shows up within one cycle in the status word, or in a clock that starts when it should stay low. Wrong capture ordering shows up only at the end of the frame, when the read data is written back into the frame word.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   // register selects on the write/read ports
   typedef enum logic [1:0] {
      SEL_FRAME  = 2'd0,
      SEL_SPEED  = 2'd1,
      SEL_STATUS = 2'd2
   } reg_sel_e;

   localparam int STAT_EVT_BIT  = 0;
   localparam int STAT_BUSY_BIT = 1;

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = en && (cnt_q == div);
   assign rise = wrap && !mdc;
   assign fall = wrap && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_pkg::*;
#(
   parameter int FRAME_W = 32,
   parameter int DATA_W  = 16,
   parameter int DIV_W   = 6,
   parameter int HOLD_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [1:0]         reg_addr,
   input  logic [FRAME_W-1:0] reg_wdata,
   input  logic [1:0]         reg_raddr,
   output logic [FRAME_W-1:0] reg_rdata,
   input  logic               busy,
   input  logic               done,
   input  logic               is_read,
   input  logic [DATA_W-1:0]  rd_data,
   output logic               launch,
   output logic [FRAME_W-1:0] l_frame,
   output logic [DIV_W-1:0]   l_div,
   output logic [HOLD_W-1:0]  l_hold,
   output logic               l_nopre,
   output logic               evt,
   output logic [FRAME_W-1:0] frame_o,
   output logic               ctl_nz
);

   localparam int SPD_W = DIV_W + HOLD_W + 2;
   localparam int CTL_W = DIV_W + 2;

   logic [FRAME_W-1:0] frame_q;
   logic [SPD_W-1:0]   speed_q;
   logic [SPD_W-1:0]   cfg_src;
   logic               wr_frame, wr_speed, wr_stat;
   logic               go_frame, go_speed;

   assign wr_frame = reg_we && (reg_addr == SEL_FRAME);
   assign wr_speed = reg_we && (reg_addr == SEL_SPEED);
   assign wr_stat  = reg_we && (reg_addr == SEL_STATUS);

   assign ctl_nz   = |speed_q[CTL_W-1:0];

   assign go_frame = wr_frame && !busy && ctl_nz;
   assign go_speed = wr_speed && !busy && (|frame_q) && !ctl_nz
                     && (|reg_wdata[CTL_W-1:0]);
   assign launch   = go_frame || go_speed;

   assign l_frame  = go_frame ? reg_wdata : frame_q;
   assign cfg_src  = wr_speed ? reg_wdata[SPD_W-1:0] : speed_q;
   assign l_div    = cfg_src[DIV_W:1];
   assign l_nopre  = cfg_src[DIV_W+1];
   assign l_hold   = cfg_src[SPD_W-1:DIV_W+2];

   assign frame_o  = frame_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         speed_q <= '0;
         evt     <= 1'b0;
      end else begin
         if (wr_frame && !busy)
            frame_q <= reg_wdata;
         else if (done && is_read)
            frame_q[DATA_W-1:0] <= rd_data;

         if (wr_speed)
            speed_q <= reg_wdata[SPD_W-1:0];

         if (done)
            evt <= 1'b1;
         else if (wr_stat && reg_wdata[STAT_EVT_BIT])
            evt <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_raddr)
         SEL_FRAME:  reg_rdata = frame_q;
         SEL_SPEED:  reg_rdata = {{(FRAME_W-SPD_W){1'b0}}, speed_q};
         SEL_STATUS: begin
            reg_rdata[STAT_EVT_BIT]  = evt;
            reg_rdata[STAT_BUSY_BIT] = busy;
         end
         default:    reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine #(
   parameter int FRAME_W = 32,
   parameter int DATA_W  = 16,
   parameter int TA_W    = 2,
   parameter int PRE_LEN = 32,
   parameter int DIV_W   = 6,
   parameter int HOLD_W  = 3,
   parameter int IN_SYNC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic [FRAME_W-1:0] l_frame,
   input  logic [DIV_W-1:0]   l_div,
   input  logic [HOLD_W-1:0]  l_hold,
   input  logic               l_nopre,
   input  logic               rise,
   input  logic               fall,
   input  logic               mdio_in,
   output logic               busy,
   output logic               done,
   output logic               is_read,
   output logic [DATA_W-1:0]  rd_data,
   output logic [DIV_W-1:0]   div_o,
   output logic               clk_en,
   output logic               mdio_out,
   output logic               mdio_oe
);

   localparam int TOT    = PRE_LEN + FRAME_W;
   localparam int IDX_W  = $clog2(TOT);
   localparam int FIDX_W = $clog2(FRAME_W);
   localparam int OP_BIT = FRAME_W - 3;
   localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(TOT - 1);
   localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(FRAME_W - 1);
   localparam logic [IDX_W-1:0] IDX_REL   = IDX_W'(DATA_W + TA_W);
   localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(DATA_W);
   localparam logic [IDX_W-1:0] IDX_FRM   = IDX_W'(FRAME_W);

   logic               busy_q;
   logic [IDX_W-1:0]   idx_q;
   logic [FRAME_W-1:0] frame_q;
   logic [DIV_W-1:0]   div_q;
   logic [HOLD_W-1:0]  hold_q;
   logic [DATA_W-1:0]  rdsh_q;
   logic               pend_q, pend_o_q, pend_oe_q;
   logic [HOLD_W-1:0]  hcnt_q;
   logic               out_q, oe_q;
   logic               din;
   logic [IDX_W-1:0]   start_idx;
   logic               sched, s_o, s_oe;
   logic [HOLD_W-1:0]  s_hold;

   // input synchronizer, depth picked by parameter
   generate
      if (IN_SYNC == 0) begin : g_nosync
         assign din = mdio_in;
      end else begin : g_sync
         logic [IN_SYNC-1:0] sff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sff_q <= '1;
            end else begin
               sff_q[0] <= mdio_in;
               for (int i = 1; i < IN_SYNC; i++)
                  sff_q[i] <= sff_q[i-1];
            end
         end
         assign din = sff_q[IN_SYNC-1];
      end
   endgenerate

   function automatic logic bit_of(input logic [FRAME_W-1:0] f,
                                   input logic [IDX_W-1:0]   i);
      if (i >= IDX_FRM) return 1'b1;
      return f[i[FIDX_W-1:0]];
   endfunction

   function automatic logic oe_of(input logic [FRAME_W-1:0] f,
                                  input logic [IDX_W-1:0]   i);
      return !(f[OP_BIT] && (i < IDX_REL));
   endfunction

   assign start_idx = l_nopre ? IDX_SHORT : IDX_LONG;
   assign done      = busy_q && fall && (idx_q == '0);
   assign busy      = busy_q;
   assign is_read   = frame_q[OP_BIT];
   assign rd_data   = rdsh_q;
   assign div_o     = div_q;
   assign clk_en    = busy_q && (div_q != '0);
   assign mdio_out  = out_q;
   assign mdio_oe   = oe_q;

   // next bit to present after the hold window
   always_comb begin
      sched  = 1'b0;
      s_o    = 1'b1;
      s_oe   = 1'b0;
      s_hold = hold_q;
      if (launch) begin
         sched  = 1'b1;
         s_o    = bit_of(l_frame, start_idx);
         s_oe   = oe_of(l_frame, start_idx);
         s_hold = l_hold;
      end else if (busy_q && fall) begin
         sched = 1'b1;
         if (idx_q != '0) begin
            s_o  = bit_of(frame_q, idx_q - 1'b1);
            s_oe = oe_of(frame_q, idx_q - 1'b1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         idx_q   <= '0;
         frame_q <= '0;
         div_q   <= '0;
         hold_q  <= '0;
         rdsh_q  <= '0;
      end else begin
         if (launch) begin
            busy_q  <= 1'b1;
            idx_q   <= start_idx;
            frame_q <= l_frame;
            div_q   <= l_div;
            hold_q  <= l_hold;
            rdsh_q  <= '0;
         end else if (busy_q && fall) begin
            if (idx_q == '0)
               busy_q <= 1'b0;
            else
               idx_q <= idx_q - 1'b1;
         end
         if (busy_q && rise && frame_q[OP_BIT] && (idx_q < IDX_DATA))
            rdsh_q <= {rdsh_q[DATA_W-2:0], din};
      end
   end

   // hold window: apply the scheduled value hold+1 cycles after the event
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         pend_o_q  <= 1'b1;
         pend_oe_q <= 1'b0;
         hcnt_q    <= '0;
         out_q     <= 1'b1;
         oe_q      <= 1'b0;
      end else if (sched) begin
         pend_q    <= 1'b1;
         pend_o_q  <= s_o;
         pend_oe_q <= s_oe;
         hcnt_q    <= s_hold;
      end else if (pend_q) begin
         if (hcnt_q == '0) begin
            pend_q <= 1'b0;
            out_q  <= pend_o_q;
            oe_q   <= pend_oe_q;
         end else begin
            hcnt_q <= hcnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
   parameter int FRAME_W = 32,
   parameter int DATA_W  = 16,
   parameter int TA_W    = 2,
   parameter int PRE_LEN = 32,
   parameter int DIV_W   = 6,
   parameter int HOLD_W  = 3,
   parameter int IN_SYNC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [1:0]         reg_addr,
   input  logic [FRAME_W-1:0] reg_wdata,
   input  logic [1:0]         reg_raddr,
   output logic [FRAME_W-1:0] reg_rdata,
   input  logic               mdio_in,
   output logic               mdc,
   output logic               mdio_out,
   output logic               mdio_oe,
   output logic               mgmt_evt
);

   localparam int SPD_W = DIV_W + HOLD_W + 2;

   generate
      if (SPD_W > FRAME_W) begin : g_bad_spd
         $error("timing word does not fit the register width");
      end
      if (FRAME_W < DATA_W + TA_W + 4) begin : g_bad_frm
         $error("frame too short for its fields");
      end
      if (DATA_W < 2 || HOLD_W < 1 || DIV_W < 1 || PRE_LEN < 1) begin : g_bad_w
         $error("field width parameter out of range");
      end
      if (IN_SYNC < 0) begin : g_bad_sync
         $error("synchronizer depth negative");
      end
   endgenerate

   logic               launch, l_nopre;
   logic [FRAME_W-1:0] l_frame, frame_cur;
   logic [DIV_W-1:0]   l_div, eng_div;
   logic [HOLD_W-1:0]  l_hold;
   logic               eng_busy, eng_done, eng_read, clk_en;
   logic [DATA_W-1:0]  eng_rd;
   logic               mdc_rise, mdc_fall, spd_lo_nz;

   mdio_regs #(
      .FRAME_W(FRAME_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .HOLD_W(HOLD_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .busy(eng_busy), .done(eng_done), .is_read(eng_read), .rd_data(eng_rd),
      .launch(launch), .l_frame(l_frame), .l_div(l_div), .l_hold(l_hold),
      .l_nopre(l_nopre), .evt(mgmt_evt), .frame_o(frame_cur), .ctl_nz(spd_lo_nz)
   );

   mdio_engine #(
      .FRAME_W(FRAME_W), .DATA_W(DATA_W), .TA_W(TA_W), .PRE_LEN(PRE_LEN),
      .DIV_W(DIV_W), .HOLD_W(HOLD_W), .IN_SYNC(IN_SYNC)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .launch(launch), .l_frame(l_frame), .l_div(l_div), .l_hold(l_hold),
      .l_nopre(l_nopre), .rise(mdc_rise), .fall(mdc_fall), .mdio_in(mdio_in),
      .busy(eng_busy), .done(eng_done), .is_read(eng_read), .rd_data(eng_rd),
      .div_o(eng_div), .clk_en(clk_en), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
   );

   mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .en(clk_en), .div(eng_div),
      .mdc(mdc), .rise(mdc_rise), .fall(mdc_fall)
   );

endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk
   import mdio_pkg::*;
#(
   parameter int FRAME_W = 32,
   parameter int DATA_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [1:0]         reg_addr,
   input logic [FRAME_W-1:0] reg_wdata,
   input logic               mdc,
   input logic               busy,
   input logic               evt,
   input logic               spd_lo_nz,
   input logic [FRAME_W-1:0] frame
);

   // R1, R2: no transfer ever starts while the control byte is zero
   p_launch_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> spd_lo_nz);

   // R1: frame writes during a transfer leave the header untouched
   p_frame_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we && reg_addr == SEL_FRAME)
      |=> $stable(frame[FRAME_W-1:DATA_W]));

   // R3: clock rests low whenever no transfer runs
   p_idle_mdc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R8: completion always leaves the event set
   p_done_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> evt);

   // R8: event only falls through a write-one clear
   p_event_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !(reg_we && reg_addr == SEL_STATUS && reg_wdata[STAT_EVT_BIT]))
      |=> evt);

endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk #(
   .FRAME_W(FRAME_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .mdc(mdc), .busy(eng_busy), .evt(mgmt_evt),
   .spd_lo_nz(spd_lo_nz), .frame(frame_cur)
);

// File: tb/sim_mdio_frame_ctrl.sv
module sim_mdio_frame_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  reg_raddr = 2'd0;
   logic [31:0] reg_rdata;
   logic        mdio_in = 1'b1;
   logic        mdc, mdio_out, mdio_oe, mgmt_evt;

   always #5 clk = ~clk;

   mdio_frame_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .mdio_in(mdio_in), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
      .mgmt_evt(mgmt_evt)
   );

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  finished = 0;

   // capture of the line at each rising clock edge
   int   rises = 0;
   logic cap_o [128];
   logic cap_oe[128];
   time  t_r0, t_r1, last_neg;
   bit   neg_seen = 0;
   bit   hold_on = 0;
   bit   phy_on = 0;
   int   exp_hold = 0;
   int   n_cur = 64;
   logic [15:0] phy_val = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial forever begin
      @(posedge mdc);
      #1;
      if (rises < 128) begin
         cap_o[rises]  = mdio_out;
         cap_oe[rises] = mdio_oe;
      end
      if (rises == 0) t_r0 = $time;
      if (rises == 1) t_r1 = $time;
      rises++;
   end

   // PHY responder: drives read data after each falling edge
   initial forever begin
      @(negedge mdc);
      begin
         int k;
         last_neg = $time;
         neg_seen = 1;
         k = rises;
         if (phy_on && k >= n_cur - 16 && k < n_cur)
            mdio_in = phy_val[n_cur - 1 - k];
      end
   end

   // hold-time monitor (R5)
   initial forever begin
      @(mdio_out);
      if (hold_on && neg_seen)
         chk("R5 hold delay", 32'($time - last_neg), 32'((exp_hold + 1) * 10));
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_raddr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 20000; i++) begin
         rd(2'd2, s);
         if (!s[1]) return;
      end
      chk("R9 busy never cleared", 32'd1, 32'd0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [31:0] spd(input int div, input int hold, input bit nopre);
      return 32'((hold << 8) | (int'(nopre) << 7) | (div << 1));
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      rd(2'd0, v); chk("R10 frame reset", v, 32'h0);
      rd(2'd1, v); chk("R10 timing reset", v, 32'h0);
      rd(2'd2, v); chk("R10 status reset", v, 32'h0);
      chk("R10 mdc low", 32'(mdc), 32'd0);
      chk("R10 oe low", 32'(mdio_oe), 32'd0);
   endtask

   // one full transaction with bit-level checks
   task automatic run_frame(input logic [31:0] fr, input int div, input int hold,
                            input bit nopre, input logic [15:0] phy);
      logic [31:0] v;
      int n;
      bit rdf;
      n = nopre ? 32 : 64;
      rdf = fr[29];
      wr(2'd2, 32'h1);
      wr(2'd1, spd(div, hold, nopre));
      rises = 0; neg_seen = 0; n_cur = n; phy_val = phy;
      exp_hold = hold; phy_on = 1; hold_on = 1;
      wr(2'd0, fr);
      rd(2'd2, v); chk("R9 busy after launch", 32'(v[1]), 32'd1);
      wait_idle();
      repeat (hold + 3) @(negedge clk);
      hold_on = 0; phy_on = 0; mdio_in = 1'b1;
      chk("R3 clock period", 32'(t_r1 - t_r0), 32'(2 * (div + 1) * 10));
      chk("R4 bit count", 32'(rises), 32'(n));
      for (int i = 0; i < n; i++) begin
         int idx;
         logic eb, eoe;
         idx = n - 1 - i;
         eb  = (idx >= 32) ? 1'b1 : fr[idx];
         eoe = !(rdf && idx < 18);
         chk(rdf ? "R6 drive enable" : "R7 drive enable", 32'(cap_oe[i]), 32'(eoe));
         if (eoe) chk(idx >= 32 ? "R4 preamble bit" : "R5 frame bit",
                      32'(cap_o[i]), 32'(eb));
      end
      rd(2'd0, v);
      if (rdf) chk("R6 read data stored", v, {fr[31:16], phy});
      else     chk("R7 frame unchanged", v, fr);
      rd(2'd2, v); chk("R8 event set", v, 32'h1);
      chk("R8 event pin", 32'(mgmt_evt), 32'd1);
   endtask

   task automatic t_c22_write();
      run_frame({2'b01, 2'b01, 5'd3, 5'd9, 2'b10, 16'hA5C3}, 3, 1, 0, 16'h0);
   endtask

   task automatic t_c22_read_nopre();
      run_frame({2'b01, 2'b10, 5'd17, 5'd2, 2'b10, 16'h0000}, 2, 0, 1, 16'h9E37);
   endtask

   task automatic t_c45_read();
      run_frame({2'b00, 2'b11, 5'd5, 5'd1, 2'b10, 16'h0000}, 4, 2, 0, 16'h3C0F);
   endtask

   task automatic t_c45_addr();
      run_frame({2'b00, 2'b00, 5'd5, 5'd1, 2'b10, 16'h1234}, 1, 0, 1, 16'h0);
   endtask

   task automatic t_event();
      logic [31:0] v;
      wr(2'd2, 32'h0);
      rd(2'd2, v); chk("R8 write 0 keeps event", v, 32'h1);
      wr(2'd2, 32'h1);
      rd(2'd2, v); chk("R8 write 1 clears event", v, 32'h0);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      logic [31:0] fa, fb;
      fa = {2'b01, 2'b01, 5'd1, 5'd4, 2'b10, 16'h00FF};
      fb = {2'b01, 2'b10, 5'd30, 5'd30, 2'b10, 16'hFFFF};
      wr(2'd1, spd(1, 0, 0));
      rises = 0;
      wr(2'd0, fa);
      repeat (10) @(negedge clk);
      wr(2'd0, fb);
      rd(2'd2, v); chk("R1 still busy", 32'(v[1]), 32'd1);
      wait_idle();
      repeat (20) @(negedge clk);
      rd(2'd0, v); chk("R1 busy write ignored", v, fa);
      chk("R1 single transfer", 32'(rises), 32'd64);
      wr(2'd2, 32'h1);
   endtask

   task automatic t_speed_launch();
      logic [31:0] v;
      logic [31:0] f;
      f = {2'b01, 2'b01, 5'd7, 5'd7, 2'b10, 16'h0F0F};
      wr(2'd1, 32'h0);
      rises = 0;
      wr(2'd0, f);
      repeat (20) @(negedge clk);
      rd(2'd2, v); chk("R1 no launch with zero control", v, 32'h0);
      chk("R1 no clock", 32'(rises), 32'd0);
      wr(2'd1, spd(1, 0, 0));
      rd(2'd2, v); chk("R2 timing write launches", 32'(v[1]), 32'd1);
      wait_idle();
      chk("R2 launched frame length", 32'(rises), 32'd64);
      rd(2'd0, v); chk("R2 frame kept", v, f);
      wr(2'd2, 32'h1);
      rises = 0;
      wr(2'd1, spd(2, 0, 0));
      repeat (20) @(negedge clk);
      rd(2'd2, v); chk("R2 nonzero-to-nonzero no launch", v, 32'h0);
      wr(2'd1, 32'h0);
      wr(2'd0, 32'h0);
      wr(2'd1, spd(1, 0, 0));
      repeat (20) @(negedge clk);
      rd(2'd2, v); chk("R2 zero frame no launch", v, 32'h0);
      chk("R2 no clock", 32'(rises), 32'd0);
   endtask

   task automatic t_div_zero();
      logic [31:0] v;
      wr(2'd1, 32'h0);
      wr(2'd0, {2'b01, 2'b01, 5'd2, 5'd2, 2'b10, 16'h5555});
      rises = 0;
      wr(2'd1, 32'h80);
      repeat (100) @(negedge clk);
      rd(2'd2, v); chk("R3 zero divider busy", 32'(v[1]), 32'd1);
      chk("R3 zero divider no edges", 32'(rises), 32'd0);
      chk("R3 zero divider clock low", 32'(mdc), 32'd0);
   endtask

   initial begin
      do_reset();
      t_reset();
      t_c22_write();
      t_event();
      t_c22_read_nopre();
      t_c45_read();
      t_c45_addr();
      t_busy_ignore();
      t_speed_launch();
      t_div_zero();
      do_reset();
      t_reset();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!finished) begin
         finished = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule